// File: doc/BRIEF.md
# Destructive-Read Memory Access Controller

This controller connects a CPU-style request/ready bus to a memory array where reading a word erases it. It accepts 16-bit word reads, word writes and single-byte writes. Every array read is followed by an internal restore write of the same data to the same address. The bus is stalled until that restore has completed, so from the bus side the memory behaves like plain SRAM.

The length of each access is set by two wait counts that are programmed independently. The access count sets how many cycles the array gets to deliver or take data. The cycle count sets the minimum total stall of one access. An automatic mode replaces both counts with fixed values. A byte write is carried out as a read-modify-write inside the controller. Its merged write restores the lane that is not written and updates the lane that is. A request that arrives while the controller is busy stays pending on the bus and is accepted as soon as the controller is idle again.

Top module: `dr_mem_ctrl`

## Requirements
- R1: While in reset and while `rdy_o` is high, `rdy_o` is 1 and `mem_en_o` is 0, so an idle controller does not touch the array.
- R2: A read (`we_i`=0) returns the stored word on `rdata_o`, and the value is valid from the first cycle in which `rdy_o` is high again. `be_i` is ignored for reads.
- R3: Every array read is followed, before `rdy_o` returns high, by one restore write to the same address with the data just read. The restore write is flagged by `mem_wb_o`=1. A later read of the same address returns the original word.
- R4: A word write (`be_i`=2'b11) stores `wdata_i` with a single array write. It issues no array read, and `mem_wb_o` stays 0.
- R5: A byte write uses `be_i` bit 0 for bits 7:0 and bit 1 for bits 15:8. Only the enabled lane takes new data, and the other lane keeps its old value. `be_i`=2'b00 changes nothing.
- R6: With `auto_i`=0, the effective access count is A = max(`acc_wait_i`,1) and the effective cycle count is C = `cyc_wait_i`. `rdy_o` is low for exactly max(A+1, C) cycles after a read or byte write is accepted, and for max(A, C) cycles after a word write.
- R7: With `auto_i`=1, A=1 and C=2 regardless of `acc_wait_i` and `cyc_wait_i`. Every kind of access then stalls for 2 cycles.
- R8: A request is accepted at a clock edge where `req_i`=1 and `rdy_o`=1, and `rdy_o` is 0 in the following cycle. A request that is held asserted during a busy access is accepted at the first edge after `rdy_o` rises and is not lost.
- R9: The wait settings and the operation fields are captured at acceptance. Changing them while the controller is busy has no effect on the running access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until accepted |
| we_i | input | 1 | 1 = write, 0 = read |
| be_i | input | 2 | Byte-lane enables for writes |
| addr_i | input | 8 | Word address |
| wdata_i | input | 16 | Write data |
| auto_i | input | 1 | Automatic wait mode |
| acc_wait_i | input | 4 | Programmed access wait count |
| cyc_wait_i | input | 4 | Programmed cycle wait count |
| rdy_o | output | 1 | Controller idle and able to accept |
| rdata_o | output | 16 | Data of the last read |
| mem_en_o | output | 1 | Array cycle enable |
| mem_we_o | output | 1 | Array write enable |
| mem_wb_o | output | 1 | Marks the internal restore write |
| mem_addr_o | output | 8 | Array address |
| mem_wdata_o | output | 16 | Array write data |
| mem_rdata_i | input | 16 | Array read data, valid the cycle after a read |

## Verification
After the acceptance edge, `rdy_o` falls in the next cycle and stays low for max(A+1,C) cycles for reads and byte writes, and for max(A,C) cycles for word writes. Read data is due on `rdata_o` in the first cycle in which `rdy_o` is high again. The bench drives every input on the falling edge and counts the falling edges at which `rdy_o` is low, which gives the stall length directly without racing the active edge. Data and restore writes are sampled on a falling edge once `rdy_o` has returned. The array model erases a word on every read, so a missing or wrong restore write appears as a wrong value on the following read of that address.

// File: rtl/dr_mem_pkg.sv
package dr_mem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACC,
    ST_WB,
    ST_PAD
  } dr_state_e;

  typedef enum logic [1:0] {
    KIND_RD,
    KIND_RMW,
    KIND_WR
  } dr_kind_e;

endpackage

// File: rtl/dr_wait_cfg.sv
module dr_wait_cfg #(
  parameter int unsigned CW       = 4,
  parameter int unsigned AUTO_ACC = 1,
  parameter int unsigned AUTO_CYC = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          auto_i,
  input  logic [CW-1:0] acc_i,
  input  logic [CW-1:0] cyc_i,
  output logic [CW-1:0] acc_o,
  output logic [CW-1:0] cyc_o
);

  localparam logic [CW-1:0] AUTO_ACC_V = CW'(AUTO_ACC);
  localparam logic [CW-1:0] AUTO_CYC_V = CW'(AUTO_CYC);
  localparam logic [CW-1:0] ONE_V      = CW'(1);

  logic [CW-1:0] acc_d, cyc_d;

  always_comb begin
    if (auto_i) begin
      acc_d = AUTO_ACC_V;
      cyc_d = AUTO_CYC_V;
    end else begin
      // access phase needs at least one cycle to launch the array cycle
      acc_d = (acc_i == '0) ? ONE_V : acc_i;
      cyc_d = cyc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_o <= AUTO_ACC_V;
      cyc_o <= AUTO_CYC_V;
    end else if (load_i) begin
      acc_o <= acc_d;
      cyc_o <= cyc_d;
    end
  end

endmodule

// File: rtl/dr_seq.sv
module dr_seq
  import dr_mem_pkg::*;
#(
  parameter int unsigned CW = 4,
  parameter int unsigned NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [NB-1:0] be_i,
  input  logic [CW-1:0] acc_w_i,
  input  logic [CW-1:0] cyc_w_i,
  output logic          idle_o,
  output logic          accept_o,
  output dr_kind_e      kind_o,
  output logic          acc_first_o,
  output logic          wb_o
);

  localparam int unsigned CNT_W = CW + 1;

  dr_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  dr_kind_e          kind_q, kind_d;
  logic              acc_done, cyc_done;

  assign idle_o   = (state_q == ST_IDLE);
  assign accept_o = idle_o && req_i;
  assign acc_done = (cnt_q >= {1'b0, acc_w_i});
  assign cyc_done = (cnt_q >= {1'b0, cyc_w_i});

  always_comb begin
    kind_d = kind_q;
    if (accept_o) begin
      if (!we_i)        kind_d = KIND_RD;
      else if (&be_i)   kind_d = KIND_WR;
      else              kind_d = KIND_RMW;
    end
  end

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          state_d = ST_ACC;
          cnt_d   = CNT_W'(1);
        end
      end
      ST_ACC: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (acc_done) begin
          if (kind_q != KIND_WR) state_d = ST_WB;
          else if (cyc_done)     state_d = ST_IDLE;
          else                   state_d = ST_PAD;
        end
      end
      ST_WB: begin
        cnt_d   = cnt_q + CNT_W'(1);
        state_d = cyc_done ? ST_IDLE : ST_PAD;
      end
      ST_PAD: begin
        cnt_d = cnt_q + CNT_W'(1);
        if (cyc_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      kind_q  <= KIND_RD;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

  assign kind_o      = kind_q;
  assign acc_first_o = (state_q == ST_ACC) && (cnt_q == CNT_W'(1));
  assign wb_o        = (state_q == ST_WB);

endmodule

// File: rtl/dr_datapath.sv
module dr_datapath
  import dr_mem_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW/8-1:0] be_i,
  input  dr_kind_e      kind_i,
  input  logic          acc_first_i,
  input  logic          wb_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic          mem_wb_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);

  localparam int unsigned NB = DW / 8;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [NB-1:0] be_q;
  logic [DW-1:0] rdata_q;
  logic [DW-1:0] merged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  for (genvar l = 0; l < NB; l++) begin : g_lane
    assign merged[l*8 +: 8] = be_q[l] ? wdata_q[l*8 +: 8] : mem_rdata_i[l*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        rdata_q <= '0;
    else if (wb_i && kind_i == KIND_RD) rdata_q <= mem_rdata_i;
  end

  always_comb begin
    unique case (kind_i)
      KIND_RD:  mem_wdata_o = mem_rdata_i;
      KIND_RMW: mem_wdata_o = merged;
      default:  mem_wdata_o = wdata_q;
    endcase
  end

  assign mem_en_o   = acc_first_i || wb_i;
  assign mem_we_o   = (acc_first_i && kind_i == KIND_WR) || wb_i;
  assign mem_wb_o   = wb_i && (kind_i == KIND_RD);
  assign mem_addr_o = addr_q;
  assign rdata_o    = rdata_q;

endmodule

// File: rtl/dr_mem_ctrl.sv
module dr_mem_ctrl
  import dr_mem_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [DW/8-1:0] be_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            auto_i,
  input  logic [CW-1:0]   acc_wait_i,
  input  logic [CW-1:0]   cyc_wait_i,
  output logic            rdy_o,
  output logic [DW-1:0]   rdata_o,
  output logic            mem_en_o,
  output logic            mem_we_o,
  output logic            mem_wb_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i
);

  localparam int unsigned NB = DW / 8;

  logic          accept, acc_first, wb;
  logic [CW-1:0] acc_w, cyc_w;
  dr_kind_e      kind;

  dr_wait_cfg #(.CW(CW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .auto_i (auto_i),
    .acc_i  (acc_wait_i),
    .cyc_i  (cyc_wait_i),
    .acc_o  (acc_w),
    .cyc_o  (cyc_w)
  );

  dr_seq #(.CW(CW), .NB(NB)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .we_i        (we_i),
    .be_i        (be_i),
    .acc_w_i     (acc_w),
    .cyc_w_i     (cyc_w),
    .idle_o      (rdy_o),
    .accept_o    (accept),
    .kind_o      (kind),
    .acc_first_o (acc_first),
    .wb_o        (wb)
  );

  dr_datapath #(.AW(AW), .DW(DW)) u_dp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .accept_i    (accept),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .be_i        (be_i),
    .kind_i      (kind),
    .acc_first_i (acc_first),
    .wb_i        (wb),
    .mem_rdata_i (mem_rdata_i),
    .rdata_o     (rdata_o),
    .mem_en_o    (mem_en_o),
    .mem_we_o    (mem_we_o),
    .mem_wb_o    (mem_wb_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o)
  );

endmodule

// File: rtl/dr_mem_ctrl_chk.sv
module dr_mem_ctrl_chk #(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic          auto_i,
  input logic [CW-1:0] acc_wait_i,
  input logic [CW-1:0] cyc_wait_i,
  input logic          rdy_o,
  input logic          mem_en_o,
  input logic          mem_we_o,
  input logic          mem_wb_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [DW-1:0] mem_rdata_i
);

  localparam int unsigned SW = CW + 2;

  logic          accept;
  logic [SW-1:0] stall_q;
  logic [CW-1:0] a_q, c_q;
  logic          pend_wb_q;

  assign accept = req_i && rdy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_q   <= '0;
      a_q       <= '0;
      c_q       <= '0;
      pend_wb_q <= 1'b0;
    end else begin
      if (accept) begin
        stall_q   <= '0;
        a_q       <= auto_i ? CW'(1) : ((acc_wait_i == '0) ? CW'(1) : acc_wait_i);
        c_q       <= auto_i ? CW'(2) : cyc_wait_i;
        pend_wb_q <= !we_i;
      end else begin
        if (!rdy_o)   stall_q   <= stall_q + SW'(1);
        if (mem_wb_o) pend_wb_q <= 1'b0;
      end
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy_o |-> !mem_en_o);

  // R3
  wb_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wb_o |-> (mem_en_o && mem_we_o && mem_wdata_o == mem_rdata_i));

  // R3
  wb_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> !pend_wb_q);

  // R6
  min_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> (stall_q >= SW'(c_q) && stall_q >= SW'(a_q)));

  // R8
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && rdy_o) |=> !rdy_o);

endmodule

bind dr_mem_ctrl dr_mem_ctrl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .auto_i      (auto_i),
  .acc_wait_i  (acc_wait_i),
  .cyc_wait_i  (cyc_wait_i),
  .rdy_o       (rdy_o),
  .mem_en_o    (mem_en_o),
  .mem_we_o    (mem_we_o),
  .mem_wb_o    (mem_wb_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/dr_mem_ctrl_bench.sv
module dr_mem_ctrl_bench;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [1:0]    be_i = 2'b00;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic          auto_i = 1'b0;
  logic [CW-1:0] acc_wait_i = '0;
  logic [CW-1:0] cyc_wait_i = '0;
  logic          rdy_o;
  logic [DW-1:0] rdata_o;
  logic          mem_en_o, mem_we_o, mem_wb_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i;

  int errors = 0;
  int checks = 0;

  always #2 clk_i = ~clk_i;

  dr_mem_ctrl #(.AW(AW), .DW(DW), .CW(CW)) u_dr_mem_ctrl (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .we_i (we_i),
    .be_i (be_i), .addr_i (addr_i), .wdata_i (wdata_i), .auto_i (auto_i),
    .acc_wait_i (acc_wait_i), .cyc_wait_i (cyc_wait_i), .rdy_o (rdy_o),
    .rdata_o (rdata_o), .mem_en_o (mem_en_o), .mem_we_o (mem_we_o),
    .mem_wb_o (mem_wb_o), .mem_addr_o (mem_addr_o), .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i)
  );

  // destructive array model: a read erases the word (stores its inverse)
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] exp_mem [DEPTH];
  int            rd_cnt = 0, wr_cnt = 0, wb_cnt = 0;
  logic [DW-1:0] wb_data = '0;
  logic [AW-1:0] wb_addr = '0;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i]     = DW'(i * 16'h0101) ^ 16'hA5C3;
      exp_mem[i] = DW'(i * 16'h0101) ^ 16'hA5C3;
    end
    mem_rdata_i = '0;
  end

  always @(posedge clk_i) begin
    if (mem_en_o) begin
      if (mem_we_o) begin
        mem[mem_addr_o] <= mem_wdata_o;
        if (mem_wb_o) begin
          wb_cnt  <= wb_cnt + 1;
          wb_data <= mem_wdata_o;
          wb_addr <= mem_addr_o;
        end else begin
          wr_cnt <= wr_cnt + 1;
        end
      end else begin
        mem_rdata_i     <= mem[mem_addr_o];
        mem[mem_addr_o] <= ~mem[mem_addr_o];
        rd_cnt          <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_stall(input bit we, input logic [1:0] be, input bit au,
                                   input int acc, input int cyc);
    int a, c, n;
    a = au ? 1 : ((acc == 0) ? 1 : acc);
    c = au ? 2 : cyc;
    n = (we && be == 2'b11) ? a : a + 1;
    return (n > c) ? n : c;
  endfunction

  task automatic access(input bit we, input logic [1:0] be, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input bit au, input int acc, input int cyc,
                        output int stall, output logic [DW-1:0] rd);
    @(negedge clk_i);
    we_i = we; be_i = be; addr_i = a; wdata_i = d;
    auto_i = au; acc_wait_i = CW'(acc); cyc_wait_i = CW'(cyc);
    req_i = 1'b1;
    stall = 0;
    @(negedge clk_i);
    while (!rdy_o) begin
      stall++;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    rd = rdata_o;
  endtask

  task automatic t_reset;
    chk(rdy_o === 1'b1 && mem_en_o === 1'b0, "R1 in reset", {rdy_o, mem_en_o}, 2'b10);
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(rdy_o === 1'b1 && mem_en_o === 1'b0, "R1 after reset", {rdy_o, mem_en_o}, 2'b10);
  endtask

  task automatic t_read_prog;
    int s, w0;
    logic [DW-1:0] r;
    w0 = wb_cnt;
    access(1'b0, 2'b00, 8'd5, '0, 1'b0, 3, 2, s, r);
    chk(s == exp_stall(0, 2'b00, 0, 3, 2), "R6 read acc=3 cyc=2 stall", s, 4);
    chk(r == exp_mem[5], "R2 read data", r, exp_mem[5]);
    chk(wb_cnt == w0 + 1 && wb_addr == 8'd5 && wb_data == exp_mem[5],
        "R3 restore write", wb_data, exp_mem[5]);
    access(1'b0, 2'b11, 8'd5, '0, 1'b0, 1, 6, s, r);
    chk(s == 6, "R6 read acc=1 cyc=6 stall", s, 6);
    chk(r == exp_mem[5], "R3 reread after restore", r, exp_mem[5]);
    access(1'b0, 2'b00, 8'd7, '0, 1'b0, 0, 0, s, r);
    chk(s == 2, "R6 read acc=0 treated as 1", s, 2);
    chk(r == exp_mem[7], "R2 read addr 7", r, exp_mem[7]);
  endtask

  task automatic t_word_write;
    int s, r0, w0;
    logic [DW-1:0] r;
    r0 = rd_cnt; w0 = wb_cnt;
    access(1'b1, 2'b11, 8'd9, 16'h3C5A, 1'b0, 3, 0, s, r);
    exp_mem[9] = 16'h3C5A;
    chk(s == exp_stall(1, 2'b11, 0, 3, 0), "R6 word write stall", s, 3);
    chk(rd_cnt == r0 && wb_cnt == w0, "R4 no array read on word write", rd_cnt - r0, 0);
    access(1'b0, 2'b00, 8'd9, '0, 1'b1, 0, 0, s, r);
    chk(r == 16'h3C5A, "R4 word write stored", r, 16'h3C5A);
  endtask

  task automatic t_byte_write;
    int s, w0;
    logic [DW-1:0] r;
    w0 = wb_cnt;
    access(1'b1, 2'b01, 8'd12, 16'hBEEF, 1'b0, 2, 0, s, r);
    exp_mem[12] = {exp_mem[12][15:8], 8'hEF};
    chk(s == 3, "R6 byte write stall", s, 3);
    chk(wb_cnt == w0, "R5 merge write not flagged as restore", wb_cnt - w0, 0);
    access(1'b0, 2'b00, 8'd12, '0, 1'b1, 0, 0, s, r);
    chk(r == exp_mem[12], "R5 low lane write", r, exp_mem[12]);
    access(1'b1, 2'b10, 8'd12, 16'h1234, 1'b1, 0, 0, s, r);
    exp_mem[12] = {8'h12, exp_mem[12][7:0]};
    access(1'b0, 2'b00, 8'd12, '0, 1'b1, 0, 0, s, r);
    chk(r == exp_mem[12], "R5 high lane write", r, exp_mem[12]);
    access(1'b1, 2'b00, 8'd12, 16'h0000, 1'b1, 0, 0, s, r);
    access(1'b0, 2'b00, 8'd12, '0, 1'b1, 0, 0, s, r);
    chk(r == exp_mem[12], "R5 no lanes enabled keeps word", r, exp_mem[12]);
  endtask

  task automatic t_auto;
    int s;
    logic [DW-1:0] r;
    access(1'b0, 2'b00, 8'd30, '0, 1'b1, 7, 9, s, r);
    chk(s == 2, "R7 auto read stall", s, 2);
    chk(r == exp_mem[30], "R7 auto read data", r, exp_mem[30]);
    access(1'b1, 2'b11, 8'd31, 16'h5555, 1'b1, 7, 9, s, r);
    exp_mem[31] = 16'h5555;
    chk(s == 2, "R7 auto word write stall", s, 2);
    access(1'b1, 2'b10, 8'd31, 16'hAA00, 1'b1, 15, 15, s, r);
    exp_mem[31] = 16'hAA55;
    chk(s == 2, "R7 auto byte write stall", s, 2);
    access(1'b0, 2'b00, 8'd31, '0, 1'b1, 0, 0, s, r);
    chk(r == 16'hAA55, "R7 auto byte write data", r, 16'hAA55);
  endtask

  task automatic t_latched_cfg;
    int s;
    @(negedge clk_i);
    we_i = 1'b0; be_i = 2'b00; addr_i = 8'd40; auto_i = 1'b0;
    acc_wait_i = 4'd5; cyc_wait_i = 4'd0; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0; acc_wait_i = 4'd1; addr_i = 8'd41; auto_i = 1'b1;
    s = 0;
    while (!rdy_o) begin
      s++;
      @(negedge clk_i);
    end
    chk(s == 6, "R9 wait settings latched at accept", s, 6);
    chk(rdata_o == exp_mem[40], "R9 address latched at accept", rdata_o, exp_mem[40]);
  endtask

  task automatic t_held;
    int s1, s2;
    logic [DW-1:0] r;
    @(negedge clk_i);
    we_i = 1'b0; be_i = 2'b00; addr_i = 8'd20; auto_i = 1'b1; req_i = 1'b1;
    @(negedge clk_i);
    chk(rdy_o == 1'b0, "R8 busy after accept", rdy_o, 0);
    // next request presented while the first access is still busy
    we_i = 1'b1; be_i = 2'b11; addr_i = 8'd21; wdata_i = 16'h1357;
    s1 = 0;
    while (!rdy_o) begin
      s1++;
      @(negedge clk_i);
    end
    chk(rdata_o == exp_mem[20], "R8 first read data", rdata_o, exp_mem[20]);
    @(negedge clk_i);
    chk(rdy_o == 1'b0, "R8 held request accepted", rdy_o, 0);
    s2 = 1;
    @(negedge clk_i);
    while (!rdy_o) begin
      s2++;
      @(negedge clk_i);
    end
    req_i = 1'b0;
    exp_mem[21] = 16'h1357;
    chk(s1 == 2 && s2 == 2, "R8 both stalls", s1 * 10 + s2, 22);
    access(1'b0, 2'b00, 8'd21, '0, 1'b1, 0, 0, s1, r);
    chk(r == 16'h1357, "R8 held write landed", r, 16'h1357);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_read_prog();
    t_word_write();
    t_byte_write();
    t_auto();
    t_latched_cfg();
    t_held();
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule